// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real page number by walking a multi-level radix tree held in memory. A start pulse supplies the address, three access qualifiers (privileged, instruction fetch, store) and the physical address of a process-table entry. The walker first reads that process-table entry. This entry gives the address-space size, the root table base and the root index width. The walker then reads one 64-bit entry per level until it reaches a leaf or finds a fault.

Memory is reached through a plain read port. The walker raises a one-cycle request with an address and waits for a valid strobe with the data. A walk ends with a one-cycle done pulse. The pulse carries either a TLB-load result, which is a real page number plus the page shift, or exactly one error flag. The error flags are segment fault, bad tree configuration, missing entry, permission fault and reference/change fault. The block does not store translations, cache entries or deliver exceptions.

Process-table entry layout: bits [60:56] size extension `rts`, bits [55:8] root base, bits [4:0] root index width. Directory entry: bit 63 valid, bit 62 clear, bits [55:8] next base, bits [4:0] next index width. Leaf entry: bits 63 and 62 set, bits [55:12] real page number, bit 8 referenced, bit 7 changed, bit 5 cache-inhibited, bit 3 privileged-only, bit 2 load-only grant, bit 1 load/store grant, bit 0 execute grant.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o` and `done_o` are low.
- R2: Each memory request lasts one cycle. A walk reads the process-table entry first and then one entry per level, so a two-level walk makes exactly three reads. The entry address is `base | (index << 3)`, where index is the `w` effective-address bits starting at bit 12 + r, `w` is the index width and `r` is the remaining count after this level.
- R3: The remaining count starts at `rts` + 19 and each level subtracts its index width. A segment fault is reported when ea[63] differs from ea[62], or when any of ea[61:31] is set above the lowest `rts` bits of that range. The segment fault takes priority over the width check.
- R4: A bad-tree fault is reported when an index width is below 5, above 16, or larger than the remaining count. This check applies at the root and at every later level.
- R5: An entry read at any level with bit 63 clear ends the walk with the missing-entry flag.
- R6: A valid entry with bit 62 set is a leaf. When it passes its checks, `tlb_load_o` is raised. `pg_shift_o` is then 12 plus the remaining count. `rpn_o` takes the leaf bits [55:12] above the page-shift boundary and the effective-address bits below it.
- R7: For a data access, permission needs leaf bit 1, or leaf bit 2 together with a non-store access.
- R8: For an instruction fetch, permission needs bit 0 set and bit 5 clear.
- R9: A leaf with bit 3 set denies permission to any access that is not privileged.
- R10: The reference/change check needs bit 8, and also bit 7 when the access is a store. A failure with permission granted raises the reference/change flag.
- R11: When both checks fail, only the permission flag is raised.
- R12: `done_o` is a one-cycle pulse with exactly one of the six outcome flags high, and the walker is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| ea_i | input | 64 | Effective address |
| priv_i | input | 1 | Privileged access |
| iside_i | input | 1 | Instruction fetch |
| store_i | input | 1 | Store access |
| ptbl_addr_i | input | PA_W | Address of the process-table entry |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | PA_W | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished, outcome valid |
| tlb_load_o | output | 1 | Translation result valid |
| rpn_o | output | PA_W-12 | Real page number |
| pg_shift_o | output | 6 | Page shift (log2 of page size) |
| err_seg_o | output | 1 | Segment fault |
| err_badtree_o | output | 1 | Bad tree configuration |
| err_nopte_o | output | 1 | Missing entry |
| err_perm_o | output | 1 | Permission fault |
| err_rc_o | output | 1 | Reference/change fault |

## Verification
The hardest case to reach from the ports is a fault deep in the tree: a bad index width or an invalid entry at the second level, or a large-page leaf found above the last level. Each of these needs a consistent chain of tables in memory. The bench builds one shared tree in a behavioural memory whose root slots lead to each such case. The effective-address bits then pick the path, so one table of vectors can reach every outcome, including a leaf that fails both checks at once.

// File: rtl/rw_pkg.sv
package rw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PT_REQ, ST_PT_WAIT, ST_CHECK, ST_REQ, ST_WAIT, ST_EVAL, ST_DONE
  } rw_state_e;

  typedef enum logic [2:0] {
    OUT_TLB, OUT_SEG, OUT_BADTREE, OUT_NOPTE, OUT_PERM, OUT_RC
  } rw_outcome_e;

  localparam int unsigned ENT_W     = 64;
  localparam int unsigned PAGE_LSB  = 12;
  localparam int unsigned ROOT_ADD  = 19;
  localparam int unsigned MIN_IDX   = 5;
  localparam int unsigned MAX_IDX   = 16;

  localparam int unsigned B_VALID = 63;
  localparam int unsigned B_LEAF  = 62;
  localparam int unsigned B_REF   = 8;
  localparam int unsigned B_CHG   = 7;
  localparam int unsigned B_CI    = 5;
  localparam int unsigned B_PRIV  = 3;
  localparam int unsigned B_RO    = 2;
  localparam int unsigned B_RW    = 1;
  localparam int unsigned B_EXEC  = 0;

  function automatic logic [30:0] f_low31(input logic [4:0] n);
    return 31'((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [5:0] f_root_remain(input logic [4:0] rts);
    return 6'(rts) + 6'(ROOT_ADD);
  endfunction

endpackage

// File: rtl/rw_seg_mask_chk.sv
module rw_seg_mask_chk
  import rw_pkg::*;
(
  input  logic [63:31] ea_hi,
  input  logic [4:0]   rts,
  input  logic [5:0]   idx_w,
  input  logic [5:0]   remain,
  output logic         seg_bad,
  output logic         mask_bad
);
  logic [30:0] allow;
  logic        excess;

  always_comb begin
    allow    = f_low31(rts);
    excess   = |(ea_hi[61:31] & ~allow);
    seg_bad  = (ea_hi[63] ^ ea_hi[62]) | excess;
    mask_bad = (idx_w < 6'(MIN_IDX)) | (idx_w > 6'(MAX_IDX)) | (idx_w > remain);
  end
endmodule

// File: rtl/rw_leaf_perm.sv
module rw_leaf_perm
  import rw_pkg::*;
(
  input  logic [8:0] flags,
  input  logic       priv,
  input  logic       iside,
  input  logic       store,
  output logic       perm_ok,
  output logic       rc_ok
);
  logic gate;

  always_comb begin
    gate = priv | ~flags[B_PRIV];
    if (iside) perm_ok = gate & flags[B_EXEC] & ~flags[B_CI];
    else       perm_ok = gate & (flags[B_RW] | (flags[B_RO] & ~store));
    rc_ok = flags[B_REF] & (flags[B_CHG] | ~store);
  end
endmodule

// File: rtl/rw_xlate.sv
module rw_xlate
  import rw_pkg::*;
#(
  parameter int unsigned PA_W  = 56,
  localparam int unsigned RPN_W = PA_W - PAGE_LSB
)(
  input  logic [63:0]      ea,
  input  logic [PA_W-1:0]  base,
  input  logic [5:0]       idx_w,
  input  logic [5:0]       remain_nx,
  input  logic [5:0]       remain,
  input  logic [RPN_W-1:0] leaf_rpn,
  output logic [PA_W-1:0]  ent_addr,
  output logic [RPN_W-1:0] rpn
);
  logic [63:0]      idx;
  logic [63:0]      keep;
  logic [RPN_W-1:0] low_mask;

  always_comb begin
    idx      = (ea >> (7'(PAGE_LSB) + 7'(remain_nx))) & ((64'd1 << idx_w) - 64'd1);
    ent_addr = base | PA_W'(idx << 3);
    keep     = (64'd1 << remain) - 64'd1;
    low_mask = keep[RPN_W-1:0];
    rpn      = (leaf_rpn & ~low_mask) | (ea[PAGE_LSB +: RPN_W] & low_mask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int unsigned PA_W = 56,
  localparam int unsigned RPN_W = PA_W - PAGE_LSB
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [63:0]      ea_i,
  input  logic             priv_i,
  input  logic             iside_i,
  input  logic             store_i,
  input  logic [PA_W-1:0]  ptbl_addr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             tlb_load_o,
  output logic [RPN_W-1:0] rpn_o,
  output logic [5:0]       pg_shift_o,
  output logic             err_seg_o,
  output logic             err_badtree_o,
  output logic             err_nopte_o,
  output logic             err_perm_o,
  output logic             err_rc_o
);
  localparam int unsigned BASE_LSB = 8;

  rw_state_e   state_q;
  rw_outcome_e out_q;
  logic [63:0]      ea_q;
  logic             priv_q, iside_q, store_q;
  logic [4:0]       rts_q;
  logic [PA_W-1:0]  base_q;
  logic [5:0]       idx_w_q;
  logic [5:0]       remain_q;
  logic [PA_W-1:0]  addr_q;
  logic [63:0]      entry_q;
  logic [RPN_W-1:0] rpn_q;
  logic [5:0]       shift_q;

  // named internal events for the checker
  logic check_evt, eval_evt, seg_bad, mask_bad, perm_ok, rc_ok;
  logic ent_valid, ent_leaf;
  logic [5:0]       remain_nx;
  logic [PA_W-1:0]  ent_addr;
  logic [RPN_W-1:0] rpn_calc;
  logic [PA_W-1:0]  next_base;
  logic             unused_bits;

  assign check_evt = (state_q == ST_CHECK);
  assign eval_evt  = (state_q == ST_EVAL);
  assign ent_valid = entry_q[B_VALID];
  assign ent_leaf  = entry_q[B_LEAF];
  assign remain_nx = remain_q - idx_w_q;
  assign next_base = {entry_q[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign unused_bits = ^{entry_q[61:PA_W], entry_q[6], mem_rdata_i[63:61], mem_rdata_i[7:5]};

  rw_seg_mask_chk u_segmask (
    .ea_hi    (ea_q[63:31]),
    .rts      (rts_q),
    .idx_w    (idx_w_q),
    .remain   (remain_q),
    .seg_bad  (seg_bad),
    .mask_bad (mask_bad)
  );

  rw_leaf_perm u_perm (
    .flags   (entry_q[8:0]),
    .priv    (priv_q),
    .iside   (iside_q),
    .store   (store_q),
    .perm_ok (perm_ok),
    .rc_ok   (rc_ok)
  );

  rw_xlate #(.PA_W(PA_W)) u_xlate (
    .ea        (ea_q),
    .base      (base_q),
    .idx_w     (idx_w_q),
    .remain_nx (remain_nx),
    .remain    (remain_q),
    .leaf_rpn  (entry_q[PA_W-1:PAGE_LSB]),
    .ent_addr  (ent_addr),
    .rpn       (rpn_calc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      out_q    <= OUT_TLB;
      ea_q     <= '0;
      priv_q   <= 1'b0;
      iside_q  <= 1'b0;
      store_q  <= 1'b0;
      rts_q    <= '0;
      base_q   <= '0;
      idx_w_q  <= '0;
      remain_q <= '0;
      addr_q   <= '0;
      entry_q  <= '0;
      rpn_q    <= '0;
      shift_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          ea_q    <= ea_i;
          priv_q  <= priv_i;
          iside_q <= iside_i;
          store_q <= store_i;
          addr_q  <= ptbl_addr_i;
          state_q <= ST_PT_REQ;
        end
        ST_PT_REQ: state_q <= ST_PT_WAIT;
        ST_PT_WAIT: if (mem_rvalid_i) begin
          rts_q    <= mem_rdata_i[60:56];
          remain_q <= f_root_remain(mem_rdata_i[60:56]);
          base_q   <= {mem_rdata_i[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
          idx_w_q  <= {1'b0, mem_rdata_i[4:0]};
          state_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (seg_bad) begin
            out_q   <= OUT_SEG;
            state_q <= ST_DONE;
          end else if (mask_bad) begin
            out_q   <= OUT_BADTREE;
            state_q <= ST_DONE;
          end else begin
            remain_q <= remain_nx;
            addr_q   <= ent_addr;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          entry_q <= mem_rdata_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!ent_valid) begin
            out_q   <= OUT_NOPTE;
            state_q <= ST_DONE;
          end else if (ent_leaf) begin
            rpn_q   <= rpn_calc;
            shift_q <= 6'(PAGE_LSB) + remain_q;
            if (!perm_ok)     out_q <= OUT_PERM;
            else if (!rc_ok)  out_q <= OUT_RC;
            else              out_q <= OUT_TLB;
            state_q <= ST_DONE;
          end else begin
            base_q  <= next_base;
            idx_w_q <= {1'b0, entry_q[4:0]};
            state_q <= ST_CHECK;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign mem_req_o     = (state_q == ST_PT_REQ) || (state_q == ST_REQ);
  assign mem_addr_o    = addr_q;
  assign rpn_o         = rpn_q;
  assign pg_shift_o    = shift_q;
  assign tlb_load_o    = done_o && (out_q == OUT_TLB);
  assign err_seg_o     = done_o && (out_q == OUT_SEG);
  assign err_badtree_o = done_o && (out_q == OUT_BADTREE);
  assign err_nopte_o   = done_o && (out_q == OUT_NOPTE);
  assign err_perm_o    = done_o && (out_q == OUT_PERM);
  assign err_rc_o      = done_o && (out_q == OUT_RC);

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic mem_req_o,
  input logic tlb_load_o,
  input logic err_seg_o,
  input logic err_badtree_o,
  input logic err_nopte_o,
  input logic err_perm_o,
  input logic err_rc_o,
  input logic check_evt,
  input logic eval_evt,
  input logic seg_bad,
  input logic mask_bad,
  input logic perm_ok,
  input logic rc_ok,
  input logic ent_valid,
  input logic ent_leaf
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy_o && !mem_req_o && !done_o));

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  assert_seg_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (check_evt && seg_bad) |=> (done_o && err_seg_o));

  assert_badtree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (check_evt && !seg_bad && mask_bad) |=> (done_o && err_badtree_o));

  assert_nopte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && !ent_valid) |=> (done_o && err_nopte_o));

  assert_leaf_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && ent_valid && ent_leaf && perm_ok && rc_ok) |=> tlb_load_o);

  assert_rc_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && ent_valid && ent_leaf && perm_ok && !rc_ok) |=> err_rc_o);

  assert_perm_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && ent_valid && ent_leaf && !perm_ok) |=> (err_perm_o && !err_rc_o));

  assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({tlb_load_o, err_seg_o, err_badtree_o,
                            err_nopte_o, err_perm_o, err_rc_o}) == 1));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_req_o     (mem_req_o),
  .tlb_load_o    (tlb_load_o),
  .err_seg_o     (err_seg_o),
  .err_badtree_o (err_badtree_o),
  .err_nopte_o   (err_nopte_o),
  .err_perm_o    (err_perm_o),
  .err_rc_o      (err_rc_o),
  .check_evt     (check_evt),
  .eval_evt      (eval_evt),
  .seg_bad       (seg_bad),
  .mask_bad      (mask_bad),
  .perm_ok       (perm_ok),
  .rc_ok         (rc_ok),
  .ent_valid     (ent_valid),
  .ent_leaf      (ent_leaf)
);

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
  localparam int unsigned PA_W  = 56;
  localparam int unsigned RPN_W = PA_W - 12;

  // outcome codes used by the bench
  localparam logic [2:0] C_TLB = 3'd0, C_SEG = 3'd1, C_BAD = 3'd2,
                         C_NOP = 3'd3, C_PRM = 3'd4, C_RC  = 3'd5, C_ILL = 3'd7;

  typedef struct packed {
    logic [63:0]      ea;
    logic             priv;
    logic             iside;
    logic             store;
    logic [2:0]       code;
    logic [RPN_W-1:0] rpn;
    logic [5:0]       shift;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{64'h0abc,                0,0,0, C_TLB, 44'h12345, 6'd12}, // R6 R7
    '{64'h0abc,                0,0,1, C_TLB, 44'h12345, 6'd12}, // R7 store
    '{64'h1010,                0,0,0, C_TLB, 44'h00777, 6'd12}, // R7 load-only
    '{64'h1010,                0,0,1, C_PRM, 44'h0, 6'd0},      // R11
    '{64'h2000,                0,0,0, C_TLB, 44'h00abc, 6'd12}, // R10
    '{64'h2000,                0,0,1, C_RC,  44'h0, 6'd0},      // R10
    '{64'h3000,                0,0,0, C_RC,  44'h0, 6'd0},      // R10
    '{64'h4000,                0,0,0, C_PRM, 44'h0, 6'd0},      // R9
    '{64'h4000,                1,0,0, C_TLB, 44'h00111, 6'd12}, // R9
    '{64'h5008,                0,1,0, C_TLB, 44'h00222, 6'd12}, // R8
    '{64'h5008,                0,0,0, C_PRM, 44'h0, 6'd0},      // R7
    '{64'h6000,                0,1,0, C_PRM, 44'h0, 6'd0},      // R8
    '{64'h7000,                0,0,0, C_NOP, 44'h0, 6'd0},      // R5 level 2
    '{64'h200000,              0,0,0, C_NOP, 44'h0, 6'd0},      // R5 root
    '{64'h453000,              0,0,0, C_TLB, 44'h40053, 6'd21}, // R6 large
    '{64'h600000,              0,0,0, C_BAD, 44'h0, 6'd0},      // R4 <5
    '{64'h800000,              0,0,0, C_BAD, 44'h0, 6'd0},      // R4 >16
    '{64'hA00000,              0,0,0, C_BAD, 44'h0, 6'd0},      // R4 >remain
    '{64'h8000_0000_0000_0000, 0,0,0, C_SEG, 44'h0, 6'd0},      // R3
    '{64'h4000_0000_0000_0000, 0,0,0, C_SEG, 44'h0, 6'd0},      // R3
    '{64'h8000_0000,           0,0,0, C_SEG, 44'h0, 6'd0},      // R3
    '{64'hC000_0000_0000_0abc, 0,0,0, C_TLB, 44'h12345, 6'd12}, // R3 pass
    '{64'h0abc,                0,1,0, C_PRM, 44'h0, 6'd0}       // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] ea = '0;
  logic priv = 1'b0, iside = 1'b0, store = 1'b0;
  logic [PA_W-1:0] ptbl = '0;
  logic mem_req;
  logic [PA_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic busy, done, tlb_load, e_seg, e_bad, e_nop, e_prm, e_rc;
  logic [RPN_W-1:0] rpn;
  logic [5:0] pg_shift;

  int n_tests = 0, n_fail = 0;
  int n_req = 0;
  logic [PA_W-1:0] addr_log [8];
  logic [2:0] got_code;
  logic [RPN_W-1:0] got_rpn;
  logic [5:0] got_shift;
  logic [63:0] mem [longint unsigned];

  always #2 clk = ~clk;

  radix_walker #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ea_i(ea), .priv_i(priv),
    .iside_i(iside), .store_i(store), .ptbl_addr_i(ptbl),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .tlb_load_o(tlb_load),
    .rpn_o(rpn), .pg_shift_o(pg_shift), .err_seg_o(e_seg), .err_badtree_o(e_bad),
    .err_nopte_o(e_nop), .err_perm_o(e_prm), .err_rc_o(e_rc)
  );

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    longint unsigned k = longint'(a);
    return mem.exists(k) ? mem[k] : 64'd0;
  endfunction

  function automatic logic [63:0] dir_ent(input logic [55:0] base, input int w);
    return 64'h8000_0000_0000_0000 | 64'(base) | 64'(w);
  endfunction

  function automatic logic [63:0] leaf_ent(input logic [43:0] pn, input logic [8:0] fl);
    return 64'hC000_0000_0000_0000 | (64'(pn) << 12) | 64'(fl);
  endfunction

  // behavioural memory: data returned two cycles after a request
  initial begin
    int pend = 0;
    logic [PA_W-1:0] pend_addr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend != 0) begin
        pend = pend - 1;
        if (pend == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(pend_addr);
        end
      end
      if (mem_req) begin
        pend = 2;
        pend_addr = mem_addr;
        if (n_req < 8) addr_log[n_req] = mem_addr;
        n_req++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] a, input logic p, input logic i,
                      input logic s, input logic [PA_W-1:0] pt);
    bit seen = 0;
    @(negedge clk);
    ea = a; priv = p; iside = i; store = s; ptbl = pt; start = 1'b1;
    n_req = 0;
    @(negedge clk);
    start = 1'b0;
    got_code = C_ILL;
    for (int c = 0; c < 300 && !seen; c++) begin
      if (done) begin
        seen = 1;
        case ({tlb_load, e_seg, e_bad, e_nop, e_prm, e_rc})
          6'b100000: got_code = C_TLB;
          6'b010000: got_code = C_SEG;
          6'b001000: got_code = C_BAD;
          6'b000100: got_code = C_NOP;
          6'b000010: got_code = C_PRM;
          6'b000001: got_code = C_RC;
          default:   got_code = C_ILL;
        endcase
        got_rpn = rpn;
        got_shift = pg_shift;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    check("R12 idle after done", {63'd0, busy}, 64'd0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // process tables
    mem[64'h0000] = 64'h0000_0000_0010_0000 | 64'd10;                 // rts 0, root 10 bits
    mem[64'h1000] = 64'h0000_0000_0010_0000 | 64'd4;                  // root width 4
    mem[64'h2000] = (64'd1 << 56) | 64'h0000_0000_0030_0000 | 64'd10; // rts 1
    // root table at 0x100000
    mem[64'h100000] = dir_ent(56'h200000, 9);
    mem[64'h100010] = leaf_ent(44'h401FF, 9'h183);
    mem[64'h100018] = dir_ent(56'h500000, 3);
    mem[64'h100020] = dir_ent(56'h500000, 17);
    mem[64'h100028] = dir_ent(56'h500000, 10);
    // second level at 0x200000
    mem[64'h200000] = leaf_ent(44'h12345, 9'h182);
    mem[64'h200008] = leaf_ent(44'h00777, 9'h104);
    mem[64'h200010] = leaf_ent(44'h00abc, 9'h102);
    mem[64'h200018] = leaf_ent(44'h00def, 9'h082);
    mem[64'h200020] = leaf_ent(44'h00111, 9'h18A);
    mem[64'h200028] = leaf_ent(44'h00222, 9'h101);
    mem[64'h200030] = leaf_ent(44'h00333, 9'h121);

    repeat (3) @(negedge clk);
    check("R1 busy after reset", {63'd0, busy}, 64'd0);
    check("R1 req after reset", {63'd0, mem_req}, 64'd0);
    check("R1 done after reset", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {62'd0, busy, done}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      walk(VECS[v].ea, VECS[v].priv, VECS[v].iside, VECS[v].store, '0);
      check($sformatf("R3-12 outcome vec %0d", v), 64'(got_code), 64'(VECS[v].code));
      if (VECS[v].code == C_TLB) begin
        check($sformatf("R6 rpn vec %0d", v), 64'(got_rpn), 64'(VECS[v].rpn));
        check($sformatf("R6 shift vec %0d", v), 64'(got_shift), 64'(VECS[v].shift));
      end
    end

    // R2: read count and addresses of a two-level walk
    walk(64'h5008, 0, 1, 0, '0);
    check("R2 read count", 64'(n_req), 64'd3);
    check("R2 ptbl address", 64'(addr_log[0]), 64'h0);
    check("R2 root address", 64'(addr_log[1]), 64'h100000);
    check("R2 leaf address", 64'(addr_log[2]), 64'h200028);

    // R4: width below minimum at the root
    walk(64'h0abc, 0, 0, 0, 56'h1000);
    check("R4 root width 4", 64'(got_code), 64'(C_BAD));
    check("R4 root stops reads", 64'(n_req), 64'd1);

    // R3: rts 1 lets bit 31 through; slot empty gives missing entry
    walk(64'h8000_0000, 0, 0, 0, 56'h2000);
    check("R3 rts allows bit 31", 64'(got_code), 64'(C_NOP));
    check("R2 rts 1 root index", 64'(addr_log[1]), 64'h301000);

    // R5: root missing entry makes two reads
    walk(64'h200000, 0, 0, 0, '0);
    check("R5 root reads", 64'(n_req), 64'd2);

    summary();
  end
endmodule